// File: doc/BRIEF.md
# Debug Mode Entry Controller

This block sits beside the retire stage of a simple in-order core and decides, every cycle, whether the core enters debug mode, takes an ordinary trap, or is redirected while already in debug mode. Its inputs are the pending events (non-maskable interrupt, a held external debug request, a trigger hit with its action bit, an interrupt and a synchronous exception) and the retire flags for ebreak, mret, ecall and dret. It also takes the current privilege level, the PC of the instruction at retire, and four base addresses. Its outputs are a fetch redirect and its target, write strobes for the debug PC and the debug cause field, write strobes for the machine exception PC and cause, and the debug-mode flag.

The block keeps the debug-mode flag, the saved debug PC and the two ebreak-enable bits of the debug control register. Access to the debug registers is checked against the debug-mode flag. A write of the enable bits lands only while the core is in debug mode.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: After reset the debug-mode flag and both ebreak-enable bits are 0, and no redirect or write strobe is raised while every event input is low.
- R2: A held debug request outside debug mode raises the redirect to the halt base, the debug PC strobe and the cause strobe with cause code 3. The debug-mode flag is 1 from the next cycle, and the current PC is kept as the debug PC.
- R3: A trigger hit with its action bit at 1 enters debug mode with cause code 2. A trigger hit with the action bit at 0 has no effect.
- R4: An ebreak outside debug mode enters debug mode with cause code 1 when its privilege's enable bit is set. The machine-mode enable applies when priv_m_i is 1, and the user-mode enable applies when it is 0.
- R5: An ebreak outside debug mode whose enable bit is 0 takes an ordinary trap. It redirects to the trap vector, raises the machine exception PC and cause strobes, and leaves debug mode off. An ecall or exception outside debug mode does the same.
- R6: When several debug causes are present in one cycle, the cause code is 2 for a trigger, otherwise 1 for an ebreak, otherwise 3.
- R7: Priority outside debug mode is NMI first, then debug entry, then interrupt, then synchronous exception. An NMI redirects to the NMI vector and raises the machine exception PC and cause strobes.
- R8: An ebreak in debug mode redirects to the halt base and raises no write strobe.
- R9: In debug mode an exception, mret or ecall redirects to the exception base and raises no write strobe. An ebreak in the same cycle wins, and the redirect goes to the halt base.
- R10: In debug mode the NMI, interrupt, debug request and trigger inputs cause no redirect.
- R11: A dret in debug mode, with no ebreak, exception, mret or ecall present, redirects to the saved debug PC, and the debug-mode flag is 0 from the next cycle. A dret outside debug mode is ignored.
- R12: A debug register access outside debug mode raises illegal_o, and a write of the enable bits there is dropped. Inside debug mode the access is legal, and a write updates the enable bits for the next cycle.
- R13: Bits [1:0] of every redirect target to the halt base or the exception base are 0, whatever the base inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pc_i | input | AW | PC of the instruction at retire |
| priv_m_i | input | 1 | 1 = machine mode, 0 = user mode |
| nmi_i | input | 1 | Pending non-maskable interrupt |
| dbg_req_i | input | 1 | Level-sensitive external debug request |
| trig_hit_i | input | 1 | Trigger match |
| trig_act_i | input | 1 | Action bit of the matching trigger (1 = enter debug) |
| irq_i | input | 1 | Pending interrupt |
| exc_i | input | 1 | Synchronous exception |
| ebreak_i | input | 1 | Ebreak retiring |
| mret_i | input | 1 | Mret retiring |
| ecall_i | input | 1 | Ecall retiring |
| dret_i | input | 1 | Dret retiring |
| halt_base_i | input | AW | Debug halt entry address |
| exc_base_i | input | AW | Debug exception entry address |
| trap_vec_i | input | AW | Ordinary trap vector |
| nmi_vec_i | input | AW | NMI vector |
| csr_acc_i | input | 1 | Access to a debug register |
| csr_we_i | input | 1 | The access is a write |
| csr_ebm_i | input | 1 | Write data for the machine ebreak enable |
| csr_ebu_i | input | 1 | Write data for the user ebreak enable |
| redir_o | output | 1 | Fetch redirect valid |
| redir_pc_o | output | AW | Fetch redirect target |
| dpc_we_o | output | 1 | Debug PC write strobe |
| dcause_we_o | output | 1 | Debug cause field write strobe |
| dcause_o | output | 3 | Debug cause code |
| mepc_we_o | output | 1 | Machine exception PC write strobe |
| mcause_we_o | output | 1 | Machine cause write strobe |
| debug_mode_o | output | 1 | Core is in debug mode |
| illegal_o | output | 1 | Illegal debug register access |
| ebm_o | output | 1 | Machine ebreak enable |
| ebu_o | output | 1 | User ebreak enable |

## Verification
The hardest case to reach from the ports is ebreak entering debug mode. The enable bits reset to 0, and they can only be written from inside debug mode. The stimulus therefore first enters through the external request, sets the machine enable with a debug register write, and leaves with dret. Only then does it retire an ebreak in machine mode, again in user mode, and together with a request to check the cause ranking. The same round trip also exercises the in-debug redirects and the dret return to the saved PC.

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] pc_i,
  input  logic          priv_m_i,
  input  logic          nmi_i,
  input  logic          dbg_req_i,
  input  logic          trig_hit_i,
  input  logic          trig_act_i,
  input  logic          irq_i,
  input  logic          exc_i,
  input  logic          ebreak_i,
  input  logic          mret_i,
  input  logic          ecall_i,
  input  logic          dret_i,
  input  logic [AW-1:0] halt_base_i,
  input  logic [AW-1:0] exc_base_i,
  input  logic [AW-1:0] trap_vec_i,
  input  logic [AW-1:0] nmi_vec_i,
  input  logic          csr_acc_i,
  input  logic          csr_we_i,
  input  logic          csr_ebm_i,
  input  logic          csr_ebu_i,
  output logic          redir_o,
  output logic [AW-1:0] redir_pc_o,
  output logic          dpc_we_o,
  output logic          dcause_we_o,
  output logic [2:0]    dcause_o,
  output logic          mepc_we_o,
  output logic          mcause_we_o,
  output logic          debug_mode_o,
  output logic          illegal_o,
  output logic          ebm_o,
  output logic          ebu_o
);

  logic          dbg_q, ebm_q, ebu_q;
  logic [AW-1:0] dpc_q;

  logic eb_en, trig_fire, eb_dbg, enter, take_nmi, take_trap;
  logic in_halt, in_exc, do_dret;

  assign eb_en     = priv_m_i ? ebm_q : ebu_q;
  assign trig_fire = trig_hit_i & trig_act_i;
  assign eb_dbg    = ebreak_i & eb_en;

  assign take_nmi  = ~dbg_q & nmi_i;
  assign enter     = ~dbg_q & ~nmi_i & (dbg_req_i | trig_fire | eb_dbg);
  assign take_trap = ~dbg_q & ~nmi_i & ~enter &
                     (irq_i | exc_i | ecall_i | (ebreak_i & ~eb_en));

  assign in_halt = dbg_q & ebreak_i;
  assign in_exc  = dbg_q & ~ebreak_i & (exc_i | mret_i | ecall_i);
  assign do_dret = dbg_q & ~ebreak_i & ~(exc_i | mret_i | ecall_i) & dret_i;

  always_comb begin
    redir_pc_o = '0;
    if (take_nmi)              redir_pc_o = nmi_vec_i;
    else if (enter || in_halt) redir_pc_o = {halt_base_i[AW-1:2], 2'b00};
    else if (take_trap)        redir_pc_o = trap_vec_i;
    else if (in_exc)           redir_pc_o = {exc_base_i[AW-1:2], 2'b00};
    else if (do_dret)          redir_pc_o = dpc_q;
  end

  assign redir_o      = take_nmi | enter | take_trap | in_halt | in_exc | do_dret;
  assign dpc_we_o     = enter;
  assign dcause_we_o  = enter;
  assign dcause_o     = !enter ? 3'd0 : trig_fire ? 3'd2 : eb_dbg ? 3'd1 : 3'd3;
  assign mepc_we_o    = take_nmi | take_trap;
  assign mcause_we_o  = take_nmi | take_trap;
  assign debug_mode_o = dbg_q;
  assign illegal_o    = csr_acc_i & ~dbg_q;
  assign ebm_o        = ebm_q;
  assign ebu_o        = ebu_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbg_q <= 1'b0;
      dpc_q <= '0;
      ebm_q <= 1'b0;
      ebu_q <= 1'b0;
    end else begin
      if (enter) begin
        dbg_q <= 1'b1;
        dpc_q <= pc_i;
      end else if (do_dret) begin
        dbg_q <= 1'b0;
      end
      if (dbg_q && csr_acc_i && csr_we_i) begin
        ebm_q <= csr_ebm_i;
        ebu_q <= csr_ebu_i;
      end
    end
  end

endmodule

// File: rtl/dbg_entry_ctrl_chk.sv
module dbg_entry_ctrl_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          nmi_i,
  input logic          ebreak_i,
  input logic          exc_i,
  input logic          mret_i,
  input logic          ecall_i,
  input logic          dret_i,
  input logic [AW-1:0] halt_base_i,
  input logic          csr_acc_i,
  input logic          redir_o,
  input logic [AW-1:0] redir_pc_o,
  input logic          dpc_we_o,
  input logic          dcause_we_o,
  input logic          mepc_we_o,
  input logic          mcause_we_o,
  input logic          debug_mode_o,
  input logic          illegal_o,
  input logic          ebm_o
);

  assert_entry_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dpc_we_o |-> (redir_o && redir_pc_o == {halt_base_i[AW-1:2], 2'b00}));

  assert_enter_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dcause_we_o |=> debug_mode_o);

  assert_trap_no_debug_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mepc_we_o |-> (!debug_mode_o && !dpc_we_o));

  assert_nmi_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_i && !debug_mode_o) |-> (mepc_we_o && !dpc_we_o));

  assert_debug_quiet_csr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    debug_mode_o |-> !(dpc_we_o || dcause_we_o || mepc_we_o || mcause_we_o));

  assert_ignore_events_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (debug_mode_o && !ebreak_i && !exc_i && !mret_i && !ecall_i && !dret_i) |-> !redir_o);

  assert_dret_exit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (debug_mode_o && dret_i && !ebreak_i && !exc_i && !mret_i && !ecall_i) |=> !debug_mode_o);

  assert_illegal_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_acc_i && !debug_mode_o) |-> illegal_o);

  assert_enable_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !debug_mode_o |=> $stable(ebm_o));

endmodule

bind dbg_entry_ctrl dbg_entry_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .nmi_i(nmi_i), .ebreak_i(ebreak_i), .exc_i(exc_i),
  .mret_i(mret_i), .ecall_i(ecall_i), .dret_i(dret_i), .halt_base_i(halt_base_i),
  .csr_acc_i(csr_acc_i), .redir_o(redir_o), .redir_pc_o(redir_pc_o),
  .dpc_we_o(dpc_we_o), .dcause_we_o(dcause_we_o), .mepc_we_o(mepc_we_o),
  .mcause_we_o(mcause_we_o), .debug_mode_o(debug_mode_o), .illegal_o(illegal_o),
  .ebm_o(ebm_o)
);

// File: tb/dbg_entry_ctrl_tb.sv
module dbg_entry_ctrl_tb;
  localparam int AW = 32;
  localparam time CLK_P = 10;
  localparam logic [AW-1:0] HALT = 32'h1A11_0803, HALT_AL = 32'h1A11_0800;
  localparam logic [AW-1:0] EXCB = 32'h1A11_0902, EXC_AL = 32'h1A11_0900;
  localparam logic [AW-1:0] TVEC = 32'h0000_0100, NVEC = 32'h0000_0200;
  localparam logic [AW-1:0] PC0 = 32'h0000_4444, PC1 = 32'h0000_5550;

  // stimulus {nmi,req,trig,act,irq,exc,ebreak,ecall}; expect {redir,tgt[1:0],dbgwe,cause[2:0],mwe}
  // tgt: 0 none, 1 NMI vector, 2 halt base, 3 trap vector
  localparam int NV = 13;
  localparam logic [15:0] VEC [NV] = '{
    {8'b1000_0000, 8'b1010_0001},
    {8'b0100_0000, 8'b1101_0110},
    {8'b0011_0000, 8'b1101_0100},
    {8'b0010_0000, 8'b0000_0000},
    {8'b0000_1000, 8'b1110_0001},
    {8'b0000_0100, 8'b1110_0001},
    {8'b0000_0010, 8'b1110_0001},
    {8'b0000_0001, 8'b1110_0001},
    {8'b1100_1000, 8'b1010_0001},
    {8'b0100_1100, 8'b1101_0110},
    {8'b0111_0000, 8'b1101_0100},
    {8'b0000_1100, 8'b1110_0001},
    {8'b0010_1000, 8'b1110_0001}
  };

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] pc_i = PC0;
  logic priv_m_i = 1;
  logic nmi_i = 0, dbg_req_i = 0, trig_hit_i = 0, trig_act_i = 0, irq_i = 0, exc_i = 0;
  logic ebreak_i = 0, mret_i = 0, ecall_i = 0, dret_i = 0;
  logic csr_acc_i = 0, csr_we_i = 0, csr_ebm_i = 0, csr_ebu_i = 0;
  logic redir_o, dpc_we_o, dcause_we_o, mepc_we_o, mcause_we_o;
  logic debug_mode_o, illegal_o, ebm_o, ebu_o;
  logic [AW-1:0] redir_pc_o;
  logic [2:0] dcause_o;

  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  dbg_entry_ctrl #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .priv_m_i(priv_m_i), .nmi_i(nmi_i),
    .dbg_req_i(dbg_req_i), .trig_hit_i(trig_hit_i), .trig_act_i(trig_act_i),
    .irq_i(irq_i), .exc_i(exc_i), .ebreak_i(ebreak_i), .mret_i(mret_i),
    .ecall_i(ecall_i), .dret_i(dret_i), .halt_base_i(HALT), .exc_base_i(EXCB),
    .trap_vec_i(TVEC), .nmi_vec_i(NVEC), .csr_acc_i(csr_acc_i), .csr_we_i(csr_we_i),
    .csr_ebm_i(csr_ebm_i), .csr_ebu_i(csr_ebu_i), .redir_o(redir_o),
    .redir_pc_o(redir_pc_o), .dpc_we_o(dpc_we_o), .dcause_we_o(dcause_we_o),
    .dcause_o(dcause_o), .mepc_we_o(mepc_we_o), .mcause_we_o(mcause_we_o),
    .debug_mode_o(debug_mode_o), .illegal_o(illegal_o), .ebm_o(ebm_o), .ebu_o(ebu_o)
  );

  task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    {nmi_i, dbg_req_i, trig_hit_i, trig_act_i, irq_i, exc_i} = '0;
    {ebreak_i, mret_i, ecall_i, dret_i, csr_acc_i, csr_we_i, csr_ebm_i, csr_ebu_i} = '0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    idle();
    priv_m_i = 1;
    pc_i = PC0;
    rst_n = 0;
    tick(); tick();
    rst_n = 1;
  endtask

  // outputs settle combinationally; sample 2 ns after driving, before the next edge
  task automatic settle();
    #2;
  endtask

  initial begin
    #(CLK_P * 5000);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [AW-1:0] exp_tgt;
    do_reset();
    settle();
    check("R1 debug_mode", debug_mode_o, 0);
    check("R1 ebm", ebm_o, 0);
    check("R1 ebu", ebu_o, 0);
    check("R1 redir", redir_o, 0);
    check("R1 strobes", {dpc_we_o, dcause_we_o, mepc_we_o, mcause_we_o}, 0);

    for (int i = 0; i < NV; i++) begin
      do_reset();
      {nmi_i, dbg_req_i, trig_hit_i, trig_act_i, irq_i, exc_i, ebreak_i, ecall_i} = VEC[i][15:8];
      settle();
      case (VEC[i][6:5])
        2'd1: exp_tgt = NVEC;
        2'd2: exp_tgt = HALT_AL;
        2'd3: exp_tgt = TVEC;
        default: exp_tgt = '0;
      endcase
      check($sformatf("R2/R3/R5/R6/R7 vec%0d redir", i), redir_o, VEC[i][7]);
      if (VEC[i][7]) check($sformatf("R7/R13 vec%0d target", i), redir_pc_o, exp_tgt);
      check($sformatf("R2 vec%0d dpc_we", i), dpc_we_o, VEC[i][4]);
      check($sformatf("R2 vec%0d dcause_we", i), dcause_we_o, VEC[i][4]);
      if (VEC[i][4]) check($sformatf("R6 vec%0d cause", i), dcause_o, VEC[i][3:1]);
      check($sformatf("R5/R7 vec%0d mepc_we", i), mepc_we_o, VEC[i][0]);
      check($sformatf("R5/R7 vec%0d mcause_we", i), mcause_we_o, VEC[i][0]);
      tick();
      check($sformatf("R2/R5 vec%0d mode after", i), debug_mode_o, VEC[i][4]);
    end

    // enter through request, then work inside debug mode
    do_reset();
    csr_acc_i = 1; csr_we_i = 1; csr_ebm_i = 1; csr_ebu_i = 1;
    settle();
    check("R12 illegal outside", illegal_o, 1);
    tick();
    check("R12 write dropped", {ebm_o, ebu_o}, 0);
    idle();
    dbg_req_i = 1;
    tick();
    idle();
    check("R2 in debug", debug_mode_o, 1);
    csr_acc_i = 1; csr_we_i = 1; csr_ebm_i = 1; csr_ebu_i = 0;
    settle();
    check("R12 legal inside", illegal_o, 0);
    tick();
    idle();
    check("R12 ebm written", ebm_o, 1);
    check("R12 ebu written", ebu_o, 0);
    nmi_i = 1; irq_i = 1; dbg_req_i = 1; trig_hit_i = 1; trig_act_i = 1;
    settle();
    check("R10 ignored events", redir_o, 0);
    tick(); idle();
    ebreak_i = 1;
    settle();
    check("R8 redir", redir_o, 1);
    check("R8 target", redir_pc_o, HALT_AL);
    check("R8 no strobes", {dpc_we_o, dcause_we_o, mepc_we_o, mcause_we_o}, 0);
    exc_i = 1;
    settle();
    check("R9 ebreak wins", redir_pc_o, HALT_AL);
    tick(); idle();
    exc_i = 1;
    settle();
    check("R9 exc target", redir_pc_o, EXC_AL);
    check("R9 exc no strobes", {dpc_we_o, dcause_we_o, mepc_we_o, mcause_we_o}, 0);
    tick(); idle();
    mret_i = 1;
    settle();
    check("R9 mret target", redir_pc_o, EXC_AL);
    tick(); idle();
    ecall_i = 1;
    settle();
    check("R9 ecall target", redir_pc_o, EXC_AL);
    tick(); idle();
    check("R9 still debug", debug_mode_o, 1);
    pc_i = PC1;
    dret_i = 1;
    settle();
    check("R11 dret redir", redir_o, 1);
    check("R11 dret target", redir_pc_o, PC0);
    tick(); idle();
    check("R11 left debug", debug_mode_o, 0);
    dret_i = 1;
    settle();
    check("R11 dret outside ignored", redir_o, 0);
    tick(); idle();

    // machine ebreak with enable set
    priv_m_i = 1; ebreak_i = 1;
    settle();
    check("R4 machine ebreak entry", dpc_we_o, 1);
    check("R4 cause", dcause_o, 1);
    check("R4 no trap", mepc_we_o, 0);
    tick(); idle();
    check("R4 in debug", debug_mode_o, 1);
    dret_i = 1;
    tick(); idle();
    check("R11 return saved pc path", debug_mode_o, 0);

    // user ebreak with user enable clear
    priv_m_i = 0; ebreak_i = 1;
    settle();
    check("R4/R5 user ebreak traps", mepc_we_o, 1);
    check("R5 trap target", redir_pc_o, TVEC);
    check("R5 no debug strobe", dpc_we_o, 0);
    tick(); idle();
    check("R5 stays out", debug_mode_o, 0);

    // ebreak together with request: ebreak cause wins
    priv_m_i = 1; ebreak_i = 1; dbg_req_i = 1;
    settle();
    check("R6 ebreak over request", dcause_o, 1);
    trig_hit_i = 1; trig_act_i = 1;
    settle();
    check("R6 trigger over ebreak", dcause_o, 2);
    tick(); idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule